// File: doc/BRIEF.md
# Bit-Packed Column Predicate Filter

This block filters one column of a table while the column streams in. The column arrives as 64-bit words. Inside them, values of a configured width (1 to 32 bits) are packed back to back with no gaps, and a value may span two words. The block first pulls each value out and right-aligns it. It then tests the value against a configured predicate: equality with an operand, an inclusive range, or membership in a 256-entry one-bit table held inside the block. Finally it encodes the verdicts as an output stream.

Two output encodings are available. The first is a match bitmap with one bit per row, emitted as a 64-bit word for every 64 rows. The second is a list of the row numbers that matched, followed by a closing beat. Both streams use valid/ready handshakes. Each side has a small queue, so a stall on the input or the output side loses nothing.

The configuration sets the value width, the predicate kind, the operands, the row count of the column and the output encoding. It must be held steady while a column is in flight. The table is loaded through its own write port before a set-membership column is run.

Top module: `colfilt_top`

## Requirements
- R1: Values are unpacked least significant bit first. Bit j of row k sits at stream bit k*W+j, where W is `cfg_width`. Stream bit b is bit b mod 64 of input word b/64, counting words in arrival order from the start of the column.
- R2: With `cfg_pred` = 0 (equality), a row matches exactly when its value equals `cfg_lo`.
- R3: With `cfg_pred` = 1 (range), a row matches exactly when `cfg_lo` <= value <= `cfg_hi`, unsigned. If `cfg_lo` > `cfg_hi`, no row matches.
- R4: With `cfg_pred` = 2 (set), a row matches when the table bit addressed by the low 8 bits of its value is 1. `tbl_we` writes `tbl_bit` to entry `tbl_addr`, and reset clears the whole table.
- R5: With `cfg_fmt` = 0 (bitmap), the verdict of row r is bit r mod 64 of output word r/64. A word is emitted as soon as its 64th row has been evaluated.
- R6: In bitmap mode the word holding the last row carries `out_last` = 1. Its bits above that row are zero. No other word carries `out_last`.
- R7: With `cfg_fmt` = 1 (index), every matching row emits one beat, in ascending row order. The row number is in bits 31:0, bits 63:32 are zero and `out_last` is 0.
- R8: In index mode, after the last row the block emits one closing beat with `out_last` = 1 and data equal to `cfg_rows`. This beat is emitted even when no row matched.
- R9: Under any pattern of stalls on `in_valid` and `out_ready`, no value or result is lost or repeated. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold.
- R10: A column ends after `cfg_rows` values. Any bits left in the word that held the last value are discarded. The next column starts at bit 0 of the next word, with row number 0.
- R11: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_width | input | 6 | Value width in bits, 1 to 32 |
| cfg_pred | input | 2 | Predicate: 0 equality, 1 range, 2 set membership |
| cfg_fmt | input | 1 | Output encoding: 0 bitmap, 1 row index list |
| cfg_lo | input | 32 | Equality operand, or lower range bound |
| cfg_hi | input | 32 | Upper range bound |
| cfg_rows | input | 32 | Number of rows in the column, at least 1 |
| tbl_we | input | 1 | Membership table write enable |
| tbl_addr | input | 8 | Membership table entry to write |
| tbl_bit | input | 1 | Bit written to the table entry |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input queue can take a word |
| in_data | input | 64 | Packed column word |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_data | output | 64 | Bitmap word or row number |
| out_last | output | 1 | Final beat of the column |

## Verification
The hardest situation to reach is a value that straddles a word boundary while both queues are stalled. Then the bit buffer must hold a partial value across idle cycles, and the encoder must hold a finished word or a closing beat. The stimulus reaches this state through widths that do not divide 64 (3, 5, 7, 13 and random ones), combined with random gaps on `in_valid` and random drops of `out_ready`. Every padding bit after the last value is filled with random data, so a column end that failed to discard them would shift the next column.

// File: rtl/cf_pkg.sv
`timescale 1ns/100ps
package cf_pkg;
  localparam logic [1:0] PRED_EQ    = 2'd0;
  localparam logic [1:0] PRED_RANGE = 2'd1;
  localparam logic [1:0] PRED_SET   = 2'd2;
  localparam logic       FMT_BITMAP = 1'b0;
  localparam logic       FMT_INDEX  = 1'b1;

  // ones in the low w bits of a 32-bit lane
  function automatic logic [31:0] low_mask(input logic [5:0] w);
    return (w >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  // verdict for one aligned value; table bit already looked up
  function automatic logic pred_hit(input logic [1:0] kind, input logic [31:0] v,
                                    input logic [31:0] lo, input logic [31:0] hi,
                                    input logic tbit);
    case (kind)
      PRED_EQ:    return v == lo;
      PRED_RANGE: return (v >= lo) && (v <= hi);
      PRED_SET:   return tbit;
      default:    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cf_fifo.sv
`timescale 1ns/100ps
module cf_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign empty = (wp_q == rp_q);
  assign full  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign dout  = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (push && !full) begin
        mem[wp_q[AW-1:0]] <= din;
        wp_q <= wp_q + 1'b1;
      end
      if (pop && !empty) rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/cf_unpack.sv
`timescale 1ns/100ps
module cf_unpack #(
  parameter int WORD_W = 64,
  parameter int VAL_W  = 32,
  parameter int ROW_W  = 32,
  parameter int WID_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word,
  output logic              val_valid,
  input  logic              val_ready,
  output logic [VAL_W-1:0]  val,
  output logic [ROW_W-1:0]  row,
  output logic              row_last
);
  import cf_pkg::*;
  localparam int BUF_W = WORD_W + VAL_W;
  localparam int CNT_W = $clog2(BUF_W + 1);

  logic [BUF_W-1:0] bits_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] need;
  logic             have;

  assign need       = CNT_W'(cfg_width);
  assign have       = (cnt_q >= need);
  assign val_valid  = have;
  assign word_ready = !have;
  assign val        = bits_q[VAL_W-1:0] & VAL_W'(low_mask(6'(cfg_width)));
  assign row        = row_q;
  assign row_last   = (row_q == cfg_rows - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      cnt_q  <= '0;
      row_q  <= '0;
    end else if (have && val_ready) begin
      if (row_last) begin
        bits_q <= '0;
        cnt_q  <= '0;
        row_q  <= '0;
      end else begin
        bits_q <= bits_q >> cfg_width;
        cnt_q  <= cnt_q - need;
        row_q  <= row_q + 1'b1;
      end
    end else if (!have && word_valid) begin
      bits_q <= bits_q | (BUF_W'(word) << cnt_q);
      cnt_q  <= cnt_q + CNT_W'(WORD_W);
    end
  end
endmodule

// File: rtl/cf_pred.sv
`timescale 1ns/100ps
module cf_pred #(
  parameter int VAL_W  = 32,
  parameter int TBL_AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_addr,
  input  logic              tbl_bit,
  input  logic [1:0]        cfg_pred,
  input  logic [VAL_W-1:0]  cfg_lo,
  input  logic [VAL_W-1:0]  cfg_hi,
  input  logic [VAL_W-1:0]  val,
  output logic              hit
);
  import cf_pkg::*;
  localparam int TBL_N = 1 << TBL_AW;

  logic [TBL_N-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (rst) tbl_q <= '0;
    else if (tbl_we) tbl_q[tbl_addr] <= tbl_bit;
  end

  assign hit = pred_hit(cfg_pred, 32'(val), 32'(cfg_lo), 32'(cfg_hi), tbl_q[val[TBL_AW-1:0]]);
endmodule

// File: rtl/cf_encode.sv
`timescale 1ns/100ps
module cf_encode #(
  parameter int WORD_W = 64,
  parameter int ROW_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fmt,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic              v_valid,
  output logic              v_ready,
  input  logic              hit,
  input  logic [ROW_W-1:0]  row,
  input  logic              row_last,
  output logic              push,
  output logic [WORD_W:0]   push_data,
  input  logic              q_full
);
  import cf_pkg::*;
  localparam int SLOT_W = $clog2(WORD_W);

  function automatic logic [WORD_W-1:0] merge_bit(input logic [WORD_W-1:0] acc,
                                                  input logic b, input logic [SLOT_W-1:0] pos);
    return acc | (WORD_W'(b) << pos);
  endfunction

  logic [WORD_W-1:0] acc_q, acc_next;
  logic              term_q, take, word_done;
  logic [SLOT_W-1:0] slot;

  assign slot      = row[SLOT_W-1:0];
  assign v_ready   = !term_q && !q_full;
  assign take      = v_valid && v_ready;
  assign acc_next  = merge_bit(acc_q, hit, slot);
  assign word_done = (slot == '1) || row_last;

  always_comb begin
    push      = 1'b0;
    push_data = '0;
    if (term_q) begin
      push      = !q_full;
      push_data = {1'b1, WORD_W'(cfg_rows)};
    end else if (take) begin
      if (cfg_fmt == FMT_BITMAP) begin
        if (word_done) begin
          push      = 1'b1;
          push_data = {row_last, acc_next};
        end
      end else if (hit) begin
        push      = 1'b1;
        push_data = {1'b0, WORD_W'(row)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      term_q <= 1'b0;
    end else begin
      if (term_q && !q_full) term_q <= 1'b0;
      if (take) begin
        if (cfg_fmt == FMT_BITMAP) acc_q <= word_done ? '0 : acc_next;
        else if (row_last)         term_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/colfilt_top.sv
`timescale 1ns/100ps
module colfilt_top #(
  parameter int WORD_W  = 64,
  parameter int VAL_W   = 32,
  parameter int ROW_W   = 32,
  parameter int TBL_AW  = 8,
  parameter int Q_DEPTH = 4,
  parameter int WID_W   = $clog2(VAL_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WID_W-1:0]  cfg_width,
  input  logic [1:0]        cfg_pred,
  input  logic              cfg_fmt,
  input  logic [VAL_W-1:0]  cfg_lo,
  input  logic [VAL_W-1:0]  cfg_hi,
  input  logic [ROW_W-1:0]  cfg_rows,
  input  logic              tbl_we,
  input  logic [TBL_AW-1:0] tbl_addr,
  input  logic              tbl_bit,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  // named internal events, observed by the bound checker
  logic              in_full, in_empty, word_ready;
  logic [WORD_W-1:0] q_word;
  logic              val_valid, val_ready, val_lastrow, hit;
  logic [VAL_W-1:0]  val_data;
  logic [ROW_W-1:0]  val_row;
  logic              enc_push, out_full, out_empty;
  logic [WORD_W:0]   enc_data, out_beat;

  assign in_ready = !in_full;

  cf_fifo #(.W(WORD_W), .DEPTH(Q_DEPTH)) u_inq (
    .clk(clk), .rst(rst), .push(in_valid), .din(in_data), .full(in_full),
    .pop(word_ready), .dout(q_word), .empty(in_empty));

  cf_unpack #(.WORD_W(WORD_W), .VAL_W(VAL_W), .ROW_W(ROW_W), .WID_W(WID_W)) u_unpack (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_rows(cfg_rows),
    .word_valid(!in_empty), .word_ready(word_ready), .word(q_word),
    .val_valid(val_valid), .val_ready(val_ready), .val(val_data),
    .row(val_row), .row_last(val_lastrow));

  cf_pred #(.VAL_W(VAL_W), .TBL_AW(TBL_AW)) u_pred (
    .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_bit(tbl_bit),
    .cfg_pred(cfg_pred), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .val(val_data), .hit(hit));

  cf_encode #(.WORD_W(WORD_W), .ROW_W(ROW_W)) u_enc (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_rows(cfg_rows),
    .v_valid(val_valid), .v_ready(val_ready), .hit(hit), .row(val_row),
    .row_last(val_lastrow), .push(enc_push), .push_data(enc_data), .q_full(out_full));

  cf_fifo #(.W(WORD_W + 1), .DEPTH(Q_DEPTH)) u_outq (
    .clk(clk), .rst(rst), .push(enc_push), .din(enc_data), .full(out_full),
    .pop(out_ready), .dout(out_beat), .empty(out_empty));

  assign out_valid = !out_empty;
  assign out_last  = out_beat[WORD_W];
  assign out_data  = out_beat[WORD_W-1:0];
endmodule

// File: rtl/colfilt_chk.sv
`timescale 1ns/100ps
module colfilt_chk (
  input logic        clk,
  input logic        rst,
  input logic [5:0]  cfg_width,
  input logic [1:0]  cfg_pred,
  input logic        cfg_fmt,
  input logic [31:0] cfg_lo,
  input logic [31:0] cfg_hi,
  input logic [31:0] cfg_rows,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        out_last,
  input logic        val_valid,
  input logic        val_ready,
  input logic [31:0] val_data,
  input logic [31:0] val_row,
  input logic        val_lastrow,
  input logic        hit
);
  logic [31:0] exp_row;

  always_ff @(posedge clk) begin
    if (rst) exp_row <= '0;
    else if (val_valid && val_ready) exp_row <= val_lastrow ? 32'd0 : exp_row + 32'd1;
  end

  // R11
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!out_valid && in_ready));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R7
  idx_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_last && cfg_fmt) |-> (out_data[63:32] == 32'd0));

  // R8
  idx_close_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last && cfg_fmt) |-> (out_data == {32'd0, cfg_rows}));

  // R3
  range_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (val_valid && cfg_pred == 2'd1 && hit) |-> (val_data >= cfg_lo && val_data <= cfg_hi));

  // R10
  row_seq_chk: assert property (@(posedge clk) disable iff (rst)
    val_valid |-> (val_row == exp_row));

  // R1
  val_width_chk: assert property (@(posedge clk) disable iff (rst)
    (val_valid && cfg_width < 6'd32) |-> ((val_data >> cfg_width) == 32'd0));
endmodule

bind colfilt_top colfilt_chk u_chk (
  .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_pred(cfg_pred), .cfg_fmt(cfg_fmt),
  .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_rows(cfg_rows), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .val_valid(val_valid), .val_ready(val_ready), .val_data(val_data), .val_row(val_row),
  .val_lastrow(val_lastrow), .hit(hit));

// File: tb/colfilt_top_bench.sv
`timescale 1ns/100ps
module colfilt_top_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  cfg_width;
  logic [1:0]  cfg_pred;
  logic        cfg_fmt;
  logic [31:0] cfg_lo, cfg_hi, cfg_rows;
  logic        tbl_we, tbl_bit;
  logic [7:0]  tbl_addr;
  logic        in_valid, in_ready, out_valid, out_ready, out_last;
  logic [63:0] in_data, out_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] vals  [0:511];
  logic [63:0] words [0:255];
  logic [64:0] expq  [0:600];
  logic [64:0] gotq  [0:700];
  logic        tbl_m [0:255];
  int nexp, ngot;

  always #2.5 clk = ~clk;

  colfilt_top u_colfilt_top (
    .clk(clk), .rst(rst), .cfg_width(cfg_width), .cfg_pred(cfg_pred), .cfg_fmt(cfg_fmt),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_rows(cfg_rows), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_bit(tbl_bit), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last));

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(input bit ok, input string req, input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wmask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic bit ref_match(input int p, input logic [31:0] v,
                                   input logic [31:0] lo, input logic [31:0] hi);
    if (p == 0) return v == lo;
    if (p == 1) return !(v < lo) && !(v > hi);
    return tbl_m[v[7:0]];
  endfunction

  task automatic run_col(input int w, input int p, input int f, input logic [31:0] lo,
                         input logic [31:0] hi, input int rows, input string tag, input int stall);
    int nwords;
    nwords = (rows * w + 63) / 64;
    for (int r = 0; r < rows; r++) begin
      logic [31:0] v;
      v = $urandom & wmask(w);
      if (p == 0 && ($urandom % 4) == 0) v = lo;
      vals[r] = v;
    end
    for (int i = 0; i < nwords; i++) words[i] = {$urandom, $urandom};
    for (int b = 0; b < rows * w; b++) words[b / 64][b % 64] = vals[b / w][b % w];
    nexp = 0;
    if (f == 0) begin
      for (int i = 0; i < (rows + 63) / 64; i++) expq[i] = '0;
      for (int r = 0; r < rows; r++) expq[r / 64][r % 64] = ref_match(p, vals[r], lo, hi);
      nexp = (rows + 63) / 64;
      expq[nexp - 1][64] = 1'b1;
    end else begin
      for (int r = 0; r < rows; r++)
        if (ref_match(p, vals[r], lo, hi)) begin
          expq[nexp] = {1'b0, 32'd0, 32'(r)};
          nexp++;
        end
      expq[nexp] = {1'b1, 32'd0, 32'(rows)};
      nexp++;
    end
    @(negedge clk);
    cfg_width = 6'(w); cfg_pred = 2'(p); cfg_fmt = f[0];
    cfg_lo = lo; cfg_hi = hi; cfg_rows = 32'(rows);
    ngot = 0;
    fork
      begin
        for (int i = 0; i < nwords; i++) begin
          forever begin
            @(negedge clk);
            in_valid = (int'($urandom % 100) >= stall);
            in_data  = words[i];
            #1;
            if (in_valid && in_ready) break;
          end
        end
        @(negedge clk);
        in_valid = 1'b0;
      end
      begin
        forever begin
          @(negedge clk);
          out_ready = (int'($urandom % 100) >= stall);
          #1;
          if (out_valid && out_ready) begin
            gotq[ngot] = {out_last, out_data};
            ngot++;
            if (out_last || ngot > 650) break;
          end
        end
        @(negedge clk);
        out_ready = 1'b0;
      end
    join
    chk(ngot == nexp, {tag, " beat count"}, 65'(ngot), 65'(nexp));
    for (int i = 0; i < nexp && i < ngot; i++)
      chk(gotq[i] === expq[i], {tag, " beat"}, gotq[i], expq[i]);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_bit = 1'b0;
    cfg_width = 6'd8; cfg_pred = 2'd0; cfg_fmt = 1'b0;
    cfg_lo = '0; cfg_hi = '0; cfg_rows = 32'd1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: idle after reset
    chk(out_valid == 1'b0, "R11 out_valid", 65'(out_valid), 65'd0);
    chk(in_ready == 1'b1, "R11 in_ready", 65'(in_ready), 65'd1);
    // R4: load membership table
    for (int i = 0; i < 256; i++) begin
      tbl_m[i] = 1'($urandom % 2);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 8'(i); tbl_bit = tbl_m[i];
    end
    @(negedge clk);
    tbl_we = 1'b0;

    run_col(5, 0, 0, 32'd3, 32'd0, 130, "R1 R2 R5 R6", 30);
    run_col(32, 1, 1, 32'h2000_0000, 32'hB000_0000, 70, "R3 R7 R8", 30);
    run_col(13, 2, 0, 32'd0, 32'd0, 64, "R4 R5", 20);
    run_col(1, 0, 0, 32'd1, 32'd0, 65, "R1 R6", 40);
    run_col(7, 1, 1, 32'd100, 32'd50, 9, "R3 R8 empty", 0);
    run_col(3, 0, 1, 32'd2, 32'd0, 5, "R10 R7 first", 0);
    run_col(3, 0, 1, 32'd2, 32'd0, 5, "R10 R7 second", 0);
    run_col(32, 2, 1, 32'd0, 32'd0, 40, "R4 R7", 50);
    for (int k = 0; k < 6; k++) begin
      int w, p;
      logic [31:0] a, b;
      w = 1 + int'($urandom % 32);
      p = int'($urandom % 3);
      a = $urandom & wmask(w);
      b = $urandom & wmask(w);
      if (a > b) begin logic [31:0] t; t = a; a = b; b = t; end
      run_col(w, p, int'($urandom % 2), a, b, 1 + int'($urandom % 300), "R9 random", 50);
    end
    report();
    $finish;
  end
endmodule